// File: doc/BRIEF.md
# Grey Scan-Out Pixel Expander

This block turns a packed 4-bit greyscale framebuffer into a magnified colour pixel stream for a host display. Each framebuffer byte holds two horizontally adjacent grey pixels. The block reads these bytes through a read port with one cycle of latency. It unpacks each pixel and widens its grey level to one of three colour word layouts. Every pixel is repeated a fixed number of times along the line, and every line is sent the same number of times. With the default sizes, 64 rows of 64 bytes become a 512 by 256 stream.

Scan-out only happens on demand. A one-cycle invalidate pulse marks the picture as stale. The block then sends exactly one frame and clears the stale mark once the last pixel of that frame has been accepted. If an invalidate arrives while a frame is in flight, the block sends one more frame afterwards. The output is a valid/ready stream that carries end-of-line and end-of-frame markers. It sustains one pixel per cycle while the sink is ready.

Top module: `grey_scan_expander`

## Requirements
- R1: After reset, `px_valid` and `fb_rd_en` stay low until the first invalidate pulse.
- R2: While no invalidate is pending, no framebuffer reads happen and no pixels are sent.
- R3: One frame covers framebuffer rows 0..ROWS-1 in order, and each row is sent MAG times. Within a line, bytes go from address y*BPR to y*BPR+BPR-1. Bits [7:4] of a byte give the left pixel and bits [3:0] the right pixel. Each pixel is repeated MAG times in a row.
- R4: `px_eol` is high only on the last pixel of each output line. `px_eof` is high only on the last pixel of the frame, and that pixel also has `px_eol` high.
- R5: With `fmt_sel` = 0, and also for the spare code 3, the pixel word is {c,c,c} with c = {g,g}, an 8-bit value per channel.
- R6: With `fmt_sel` = 1 (RGB565), `px_data` is {8'h00, r5, g6, r5}, where r5 = 2g + (g>>3) and g6 = 4g + (g>>2).
- R7: With `fmt_sel` = 2 (15-bit), `px_data` is {9'h000, r5, r5, r5}.
- R8: While `px_valid` is high and `px_ready` is low, `px_data`, `px_eol` and `px_eof` hold their values, and no pixel is lost or repeated.
- R9: The stale mark is cleared when the end-of-frame pixel is accepted. After that, no further frame starts without a new invalidate.
- R10: An invalidate that arrives while a frame is in progress yields exactly one extra frame. This includes an invalidate in the very cycle the end-of-frame pixel is accepted.
- R11: The block has at most one framebuffer read outstanding, so `fb_rd_en` is never high on two cycles in a row. Every read address is below ROWS*BPR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| invalidate | input | 1 | One-cycle pulse that marks the picture stale |
| fmt_sel | input | 2 | Colour layout: 0/3 24-bit, 1 RGB565, 2 15-bit |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_rd_addr | output | AW (12) | Framebuffer byte address |
| fb_rd_data | input | 8 | Read data, one cycle after the strobe |
| px_ready | input | 1 | Sink accepts a pixel |
| px_valid | output | 1 | Pixel word present |
| px_data | output | 24 | Colour word |
| px_eol | output | 1 | Last pixel of an output line |
| px_eof | output | 1 | Last pixel of the frame |

## Verification
The invalidate input and the end of a frame can fall in the same cycle. In that cycle the stale mark is cleared and set again at once, and the set must win. The bench provokes this case by watching for the accepted end-of-frame pixel and pulsing invalidate during that same cycle. It judges the result by expecting exactly one further complete frame in the scoreboard and then checking that no pixel arrives afterwards. A milder form of the same overlap, an invalidate in the middle of a frame, is run as well. Random backpressure is applied so that stalls meet the byte refill path.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    FMT_RGB888 = 2'd0,
    FMT_RGB565 = 2'd1,
    FMT_RGB555 = 2'd2,
    FMT_SPARE  = 2'd3
  } pix_fmt_e;

  // Widen a 4-bit grey level by bit replication into the selected layout.
  function automatic logic [23:0] grey_to_rgb(input logic [3:0] g, input pix_fmt_e f);
    logic [4:0]  c5;
    logic [5:0]  c6;
    logic [7:0]  c8;
    logic [23:0] w;
    c5 = {g, g[3]};
    c6 = {g, g[3:2]};
    c8 = {g, g};
    case (f)
      FMT_RGB565: w = {8'h00, c5, c6, c5};
      FMT_RGB555: w = {9'h000, c5, c5, c5};
      default:    w = {c8, c8, c8};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/scan_fetch.sv
module scan_fetch #(
  parameter int ROWS = 64,
  parameter int BPR  = 64,
  parameter int MAG  = 4,
  parameter int AW   = $clog2(ROWS * BPR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          busy_i,
  input  logic          take_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic [7:0]    nxt_byte_o,
  output logic          nxt_ok_o
);
  localparam int XW = (BPR  > 1) ? $clog2(BPR)  : 1;
  localparam int YW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int MW = (MAG  > 1) ? $clog2(MAG)  : 1;
  localparam logic [XW-1:0] XLAST = XW'(BPR - 1);
  localparam logic [YW-1:0] YLAST = YW'(ROWS - 1);
  localparam logic [MW-1:0] LLAST = MW'(MAG - 1);

  logic [XW-1:0] f_x;
  logic [MW-1:0] f_l;
  logic [YW-1:0] f_y;
  logic          f_done;
  logic          pend;

  assign rd_en_o   = busy_i && !f_done && !pend && !nxt_ok_o;
  assign rd_addr_o = AW'(f_y) * AW'(BPR) + AW'(f_x);

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      f_x        <= '0;
      f_l        <= '0;
      f_y        <= '0;
      f_done     <= 1'b0;
      pend       <= 1'b0;
      nxt_ok_o   <= 1'b0;
      nxt_byte_o <= '0;
    end else begin
      pend <= rd_en_o;
      if (pend) begin
        nxt_byte_o <= rd_data_i;
        nxt_ok_o   <= 1'b1;
      end else if (take_i) begin
        nxt_ok_o <= 1'b0;
      end
      if (rd_en_o) begin
        if (f_x == XLAST) begin
          f_x <= '0;
          if (f_l == LLAST) begin
            f_l <= '0;
            if (f_y == YLAST) f_done <= 1'b1;
            else              f_y    <= f_y + 1'b1;
          end else begin
            f_l <= f_l + 1'b1;
          end
        end else begin
          f_x <= f_x + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scan_emit.sv
module scan_emit #(
  parameter int ROWS = 64,
  parameter int BPR  = 64,
  parameter int MAG  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       step_i,
  input  logic [7:0] nxt_byte_i,
  input  logic       nxt_ok_i,
  output logic       take_o,
  output logic       have_o,
  output logic [3:0] nyb_o,
  output logic       eol_o,
  output logic       eof_o
);
  localparam int XW = (BPR  > 1) ? $clog2(BPR)  : 1;
  localparam int YW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int MW = (MAG  > 1) ? $clog2(MAG)  : 1;
  localparam logic [XW-1:0] XLAST = XW'(BPR - 1);
  localparam logic [YW-1:0] YLAST = YW'(ROWS - 1);
  localparam logic [MW-1:0] MLAST = MW'(MAG - 1);

  logic [7:0]    cur_byte;
  logic [MW-1:0] e_r;
  logic          e_h;
  logic [XW-1:0] e_x;
  logic [MW-1:0] e_l;
  logic [YW-1:0] e_y;
  logic          byte_end;

  assign byte_end = e_h && (e_r == MLAST);
  assign take_o   = nxt_ok_i && (!have_o || (step_i && byte_end));
  assign nyb_o    = e_h ? cur_byte[3:0] : cur_byte[7:4];
  assign eol_o    = byte_end && (e_x == XLAST);
  assign eof_o    = eol_o && (e_l == MLAST) && (e_y == YLAST);

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      have_o   <= 1'b0;
      cur_byte <= '0;
      e_r      <= '0;
      e_h      <= 1'b0;
      e_x      <= '0;
      e_l      <= '0;
      e_y      <= '0;
    end else begin
      if (take_o) begin
        cur_byte <= nxt_byte_i;
        have_o   <= 1'b1;
      end else if (step_i && byte_end) begin
        have_o <= 1'b0;
      end
      if (step_i) begin
        if (e_r != MLAST) begin
          e_r <= e_r + 1'b1;
        end else begin
          e_r <= '0;
          e_h <= !e_h;
          if (e_h) begin
            if (e_x != XLAST) begin
              e_x <= e_x + 1'b1;
            end else begin
              e_x <= '0;
              if (e_l != MLAST) begin
                e_l <= e_l + 1'b1;
              end else begin
                e_l <= '0;
                e_y <= (e_y == YLAST) ? '0 : e_y + 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/scan_pix_out.sv
module scan_pix_out
  import scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step_i,
  input  logic [3:0]  nyb_i,
  input  logic        eol_i,
  input  logic        eof_i,
  input  pix_fmt_e    fmt_i,
  input  logic        ready_i,
  output logic        can_o,
  output logic        valid_o,
  output logic [23:0] data_o,
  output logic        eol_o,
  output logic        eof_o
);
  assign can_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      eol_o   <= 1'b0;
      eof_o   <= 1'b0;
    end else if (step_i) begin
      valid_o <= 1'b1;
      data_o  <= grey_to_rgb(nyb_i, fmt_i);
      eol_o   <= eol_i;
      eof_o   <= eof_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/grey_scan_expander.sv
module grey_scan_expander
  import scan_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int BPR  = 64,
  parameter int MAG  = 4,
  parameter int AW   = $clog2(ROWS * BPR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          invalidate,
  input  logic [1:0]    fmt_sel,
  output logic          fb_rd_en,
  output logic [AW-1:0] fb_rd_addr,
  input  logic [7:0]    fb_rd_data,
  input  logic          px_ready,
  output logic          px_valid,
  output logic [23:0]   px_data,
  output logic          px_eol,
  output logic          px_eof
);
  logic       busy, stale, again, start, done;
  logic       take, nxt_ok, have, can, step, n_eol, n_eof;
  logic [7:0] nxt_byte;
  logic [3:0] nyb;

  assign start = !busy && stale && !px_valid;
  assign done  = px_valid && px_ready && px_eof;
  assign step  = have && can;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      stale <= 1'b0;
      again <= 1'b0;
    end else begin
      if (start) busy <= 1'b1;
      else if (done) busy <= 1'b0;

      if (start) again <= 1'b0;
      else if (invalidate && busy) again <= 1'b1;

      // A fresh invalidate beats the end-of-frame clear.
      if (done) stale <= again || invalidate;
      else if (invalidate) stale <= 1'b1;
    end
  end

  scan_fetch #(.ROWS(ROWS), .BPR(BPR), .MAG(MAG), .AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .start_i(start), .busy_i(busy), .take_i(take),
    .rd_en_o(fb_rd_en), .rd_addr_o(fb_rd_addr), .rd_data_i(fb_rd_data),
    .nxt_byte_o(nxt_byte), .nxt_ok_o(nxt_ok)
  );

  scan_emit #(.ROWS(ROWS), .BPR(BPR), .MAG(MAG)) u_emit (
    .clk(clk), .rst(rst), .start_i(start), .step_i(step),
    .nxt_byte_i(nxt_byte), .nxt_ok_i(nxt_ok), .take_o(take), .have_o(have),
    .nyb_o(nyb), .eol_o(n_eol), .eof_o(n_eof)
  );

  scan_pix_out u_out (
    .clk(clk), .rst(rst), .step_i(step), .nyb_i(nyb), .eol_i(n_eol), .eof_i(n_eof),
    .fmt_i(pix_fmt_e'(fmt_sel)), .ready_i(px_ready), .can_o(can),
    .valid_o(px_valid), .data_o(px_data), .eol_o(px_eol), .eof_o(px_eof)
  );
endmodule

// File: rtl/grey_scan_expander_chk.sv
module grey_scan_expander_chk #(
  parameter int AW    = 12,
  parameter int DEPTH = 4096
) (
  input logic          clk,
  input logic          rst,
  input logic          fb_rd_en,
  input logic [AW-1:0] fb_rd_addr,
  input logic          px_ready,
  input logic          px_valid,
  input logic [23:0]   px_data,
  input logic          px_eol,
  input logic          px_eof
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!px_valid && !fb_rd_en));

  p_eof_with_eol_r4: assert property (@(posedge clk) disable iff (rst)
    (px_valid && px_eof) |-> px_eol);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_data) && $stable(px_eol) && $stable(px_eof)));

  p_one_read_r11: assert property (@(posedge clk) disable iff (rst)
    fb_rd_en |=> !fb_rd_en);

  p_addr_range_r11: assert property (@(posedge clk) disable iff (rst)
    fb_rd_en |-> (32'(fb_rd_addr) < DEPTH));
endmodule

bind grey_scan_expander grey_scan_expander_chk #(.AW(AW), .DEPTH(ROWS * BPR)) u_chk (
  .clk(clk), .rst(rst), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
  .px_ready(px_ready), .px_valid(px_valid), .px_data(px_data),
  .px_eol(px_eol), .px_eof(px_eof)
);

// File: tb/grey_scan_expander_test.sv
module grey_scan_expander_test;
  localparam int ROWS = 4;
  localparam int BPR  = 4;
  localparam int MAG  = 4;
  localparam int AW   = $clog2(ROWS * BPR);

  typedef struct {
    logic [23:0] data;
    logic        eol;
    logic        eof;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          invalidate = 1'b0;
  logic [1:0]    fmt_sel = 2'd0;
  logic          fb_rd_en;
  logic [AW-1:0] fb_rd_addr;
  logic [7:0]    fb_rd_data;
  logic          px_ready = 1'b1;
  logic          px_valid;
  logic [23:0]   px_data;
  logic          px_eol;
  logic          px_eof;

  logic [7:0] mem [ROWS*BPR];
  exp_t       q[$];
  int         checks = 0;
  int         errors = 0;
  bit         rnd_ready = 0;
  bit         finished = 0;

  always #4 clk = !clk;

  grey_scan_expander #(.ROWS(ROWS), .BPR(BPR), .MAG(MAG), .AW(AW)) uut (
    .clk(clk), .rst(rst), .invalidate(invalidate), .fmt_sel(fmt_sel),
    .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
    .px_ready(px_ready), .px_valid(px_valid), .px_data(px_data),
    .px_eol(px_eol), .px_eof(px_eof)
  );

  always_ff @(posedge clk) if (fb_rd_en) fb_rd_data <= mem[fb_rd_addr];

  function automatic logic [23:0] colour(input int g, input int f);
    int r5, g6, c;
    r5 = g * 2 + g / 8;
    g6 = g * 4 + g / 4;
    c  = g * 17;
    if (f == 1) return 24'((r5 << 11) | (g6 << 5) | r5);
    if (f == 2) return 24'((r5 << 10) | (r5 << 5) | r5);
    return 24'((c << 16) | (c << 8) | c);
  endfunction

  task automatic push_frame(input int f, input string tag);
    for (int y = 0; y < ROWS; y++)
      for (int l = 0; l < MAG; l++)
        for (int x = 0; x < BPR; x++)
          for (int h = 0; h < 2; h++)
            for (int r = 0; r < MAG; r++) begin
              exp_t e;
              int g;
              g = (h == 0) ? int'(mem[y*BPR+x][7:4]) : int'(mem[y*BPR+x][3:0]);
              e.data = colour(g, f);
              e.eol  = (x == BPR-1) && (h == 1) && (r == MAG-1);
              e.eof  = e.eol && (l == MAG-1) && (y == ROWS-1);
              e.tag  = tag;
              q.push_back(e);
            end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < ROWS*BPR; i++) mem[i] = 8'((i * 37 + seed * 11 + 5) ^ (i << 3));
  endtask

  task automatic pulse_inv();
    @(posedge clk); #1 invalidate = 1'b1;
    @(posedge clk); #1 invalidate = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((q.size() != 0 || px_valid) && n < 20000) begin @(posedge clk); n++; end
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d pixels missing, expected 0", req, q.size());
      q.delete();
    end
  endtask

  task automatic idle_check(input string req);
    int seen = 0;
    repeat (60) begin @(negedge clk); if (px_valid || fb_rd_en) seen++; end
    checks++;
    if (seen != 0) begin
      errors++;
      $display("FAIL %s: %0d busy cycles while idle, expected 0", req, seen);
    end
  endtask

  // Monitor: compare every accepted pixel, check hold during stalls (R8).
  initial begin
    logic        pstall = 0;
    logic [23:0] pdata = '0;
    logic        peol = 0, peof = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pstall) begin
          checks++;
          if (!px_valid || px_data != pdata || px_eol != peol || px_eof != peof) begin
            errors++;
            $display("FAIL R8: stalled word changed v=%0b d=%h, expected v=1 d=%h", px_valid, px_data, pdata);
          end
        end
        if (px_valid && px_ready) begin
          checks++;
          if (q.size() == 0) begin
            errors++;
            $display("FAIL R9: unexpected pixel %h, expected none", px_data);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (px_data != e.data) begin
              errors++;
              $display("FAIL R3 %s: data %h, expected %h", e.tag, px_data, e.data);
            end else if (px_eol != e.eol || px_eof != e.eof) begin
              errors++;
              $display("FAIL R4: eol/eof %0b%0b, expected %0b%0b", px_eol, px_eof, e.eol, e.eof);
            end
          end
        end
        pstall = px_valid && !px_ready;
        pdata = px_data; peol = px_eol; peof = px_eof;
      end
    end
  end

  // Ready driver: always high or pseudo-random.
  initial begin
    logic [7:0] lf = 8'h5a;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      px_ready = rnd_ready ? lf[0] : 1'b1;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    fill(1);
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    // R1 / R2: quiet after reset with no invalidate
    @(negedge clk);
    checks++;
    if (px_valid || fb_rd_en) begin
      errors++;
      $display("FAIL R1: valid=%0b rd=%0b after reset, expected 0 0", px_valid, fb_rd_en);
    end
    idle_check("R2");

    // R5: 24-bit layout, full-rate sink
    fmt_sel = 2'd0;
    push_frame(0, "R5");
    pulse_inv();
    drain("R5");
    idle_check("R9");

    // R6: RGB565 under random backpressure (R8)
    fill(2); fmt_sel = 2'd1; rnd_ready = 1;
    push_frame(1, "R6");
    pulse_inv();
    drain("R6");
    idle_check("R9");

    // R7: 15-bit
    fill(3); fmt_sel = 2'd2;
    push_frame(2, "R7");
    pulse_inv();
    drain("R7");

    // R5: spare code behaves as 24-bit
    fill(4); fmt_sel = 2'd3;
    push_frame(3, "R5");
    pulse_inv();
    drain("R5");
    idle_check("R9");

    // R10: invalidate in mid-frame gives one extra frame
    fill(5); fmt_sel = 2'd0;
    push_frame(0, "R10");
    pulse_inv();
    repeat (100) @(posedge clk);
    push_frame(0, "R10");
    pulse_inv();
    drain("R10");
    idle_check("R10");

    // R10: invalidate in the cycle the end-of-frame pixel is accepted
    rnd_ready = 0;
    @(posedge clk); #1;
    fill(6); fmt_sel = 2'd1;
    push_frame(1, "R10");
    pulse_inv();
    do @(negedge clk); while (!(px_valid && px_eof && px_ready));
    push_frame(1, "R10");
    invalidate = 1'b1;
    @(posedge clk); #1 invalidate = 1'b0;
    drain("R10");
    idle_check("R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule